// File: doc/BRIEF.md
# Flag Offset Register Sequencer

This block keeps the two threshold offsets used by a FIFO's almost-empty and almost-full flags: `n` (distance from empty) and `m` (distance from full). Each offset lives in two registers, a low byte and a narrow high part. That makes four registers in all. One cyclic pointer picks the register that each access reaches. The pointer steps through the four in a fixed order and wraps after the last.

While the load control is held low, each enabled write-side access stores the low byte of the data input into the selected register. Each enabled read-side access copies the selected register onto an 8-bit readback port and pulses a valid strobe. The pointer does not move while load is high. A load sequence that stops early therefore continues at the next register when load returns low. The block uses a single clock, so the read and write sides are tied together. The FIFO storage and the flag comparators are separate blocks that take the assembled offsets from this one.

Top module: `flag_offset_seq`

## Requirements
- R1: After a cycle with `rst_n` low, both low registers hold 7 and both high registers hold 0. So `empty_ofs` and `full_ofs` both read 7, and `rdback`, `rdback_vld` and `clash` are 0.
- R2: A write access (`load_n`=0 and `wr_en_n`=0 at a rising edge) stores `din[7:0]` into the selected register and advances the pointer by one.
- R3: The pointer order is 0 = empty low, 1 = empty high, 2 = full low, 3 = full high. An access made at position 3 returns the pointer to position 0.
- R4: With `load_n`=1, `wr_en_n` and the read enables have no effect. The offsets hold their values and the pointer keeps its position, so the next access after load returns low reaches the following register.
- R5: A read access (`load_n`=0, `rd_en1_n`=0, `rd_en2_n`=0, and no write access) puts the selected register, zero-extended to 8 bits, on `rdback` one cycle later. It raises `rdback_vld` for exactly that cycle and advances the pointer.
- R6: Reads and writes share the same pointer. A mix of read and write accesses visits the registers in the R3 order.
- R7: A high register keeps only `OFS_W-8` bits, which is 2 for `DEPTH`=1024. Data bits above that are discarded on write and read back as zero. `din[8]` is never stored.
- R8: When a write access and a read access fall in the same cycle, the write is performed and the pointer advances once. No readback happens, and `clash` is 1 for the following cycle.
- R9: Reset returns the pointer to position 0 (empty low).
- R10: `empty_ofs` is {empty high, empty low} and `full_ofs` is {full high, full low}. Both are `OFS_W` = log2(`DEPTH`) bits wide.
- R11: A read request with only one of the two read enables low is no access. There is no readback and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for loading and readback |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Low selects offset-register access |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en1_n | input | 1 | Active-low read enable, first |
| rd_en2_n | input | 1 | Active-low read enable, second |
| din | input | DIN_W (9) | Data input; low 8 bits used |
| empty_ofs | output | OFS_W (10) | Assembled almost-empty offset n |
| full_ofs | output | OFS_W (10) | Assembled almost-full offset m |
| rdback | output | 8 | Register contents read back |
| rdback_vld | output | 1 | One-cycle strobe marking a readback |
| clash | output | 1 | One-cycle strobe after a simultaneous read and write request |

## Verification
The bench builds the block at `DEPTH`=1024. That gives a 2-bit high register, so the discarded upper bits are a real case: writing all ones to a high register must read back as 3. A 9-bit `din` also lets the bench check that bit 8 is dropped. With 10-bit offsets, both assembled outputs can carry high-part values that differ from their low bytes. This shows that the bytes land in the right halves of the right offset.

// File: rtl/flag_offset_seq_pkg.sv
// Shared types and constants for the flag offset register sequencer.
package flag_offset_seq_pkg;

    // Register pointer; the encoding order is the access order.
    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } ofs_sel_t;

    localparam int unsigned LO_W       = 8;
    localparam logic [7:0]  LO_DEFAULT = 8'd7;

endpackage

// File: rtl/flag_offset_seq_sel.sv
// Cyclic register pointer.
// Steps once per accepted access and wraps from full-high to empty-low.
// Assumes: adv is already qualified by the load control.
module flag_offset_seq_sel
    import flag_offset_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    output ofs_sel_t sel
);

    // Advance on each access; the 2-bit count wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= SEL_E_LO;
        else if (adv)
            sel <= ofs_sel_t'(sel + 2'd1);
    end

endmodule

// File: rtl/flag_offset_seq_bank.sv
// The four offset registers: a low byte and a narrow high part per offset.
// Index 0 is the empty offset and index 1 is the full offset.
// Assumes: HI_W >= 1, so the high part exists.
module flag_offset_seq_bank
    import flag_offset_seq_pkg::*;
#(
    parameter int unsigned DIN_W = 9,
    parameter int unsigned HI_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  ofs_sel_t                   sel,
    input  logic [DIN_W-1:0]           din,
    output logic [1:0][LO_W-1:0]       lo_q,
    output logic [1:0][HI_W-1:0]       hi_q
);

    for (genvar k = 0; k < 2; k++) begin : g_ofs
        localparam ofs_sel_t LO_SEL = ofs_sel_t'(2 * k);
        localparam ofs_sel_t HI_SEL = ofs_sel_t'(2 * k + 1);

        // Low byte: reset to its default, load din[7:0] when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lo_q[k] <= LO_DEFAULT;
            else if (wr_stb && sel == LO_SEL)
                lo_q[k] <= din[LO_W-1:0];
        end

        // High part: reset to zero, keep only the low HI_W data bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hi_q[k] <= '0;
            else if (wr_stb && sel == HI_SEL)
                hi_q[k] <= din[HI_W-1:0];
        end
    end

endmodule

// File: rtl/flag_offset_seq_rdmux.sv
// Readback path: picks the selected register, zero-extends it and
// registers it with a one-cycle valid strobe. Also registers the clash strobe.
// Assumes: rd_stb is already suppressed when a write is granted.
module flag_offset_seq_rdmux
    import flag_offset_seq_pkg::*;
#(
    parameter int unsigned HI_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_stb,
    input  logic                 clash_in,
    input  ofs_sel_t             sel,
    input  logic [1:0][LO_W-1:0] lo_q,
    input  logic [1:0][HI_W-1:0] hi_q,
    output logic [LO_W-1:0]      rdback,
    output logic                 rdback_vld,
    output logic                 clash
);

    logic [LO_W-1:0] pick;

    // Select the addressed register; unused high bits read as zero.
    always_comb begin
        unique case (sel)
            SEL_E_LO: pick = lo_q[0];
            SEL_E_HI: pick = LO_W'(hi_q[0]);
            SEL_F_LO: pick = lo_q[1];
            default:  pick = LO_W'(hi_q[1]);
        endcase
    end

    // Capture readback data; data holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdback <= '0;
        else if (rd_stb)
            rdback <= pick;
    end

    // One-cycle strobes for readback and clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdback_vld <= 1'b0;
            clash      <= 1'b0;
        end else begin
            rdback_vld <= rd_stb;
            clash      <= clash_in;
        end
    end

endmodule

// File: rtl/flag_offset_seq.sv
// Flag offset register sequencer (top).
// Holds the almost-empty and almost-full offsets and loads or reads them
// through one cyclic pointer. A write wins over a simultaneous read.
// Assumes: one clock for both sides; DEPTH is a power of two above 256.
module flag_offset_seq
    import flag_offset_seq_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned DIN_W = 9,
    localparam int unsigned OFS_W = $clog2(DEPTH),
    localparam int unsigned HI_W  = OFS_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             wr_en_n,
    input  logic             rd_en1_n,
    input  logic             rd_en2_n,
    input  logic [DIN_W-1:0] din,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic [LO_W-1:0]  rdback,
    output logic             rdback_vld,
    output logic             clash
);

    if (OFS_W <= LO_W || DIN_W < LO_W) begin : g_bad_cfg
        $error("flag_offset_seq: DEPTH must exceed 256 and DIN_W must be at least 8");
    end

    logic                 wr_acc, rd_req, rd_stb;
    ofs_sel_t             sel;
    logic [1:0][LO_W-1:0] lo_q;
    logic [1:0][HI_W-1:0] hi_q;

    // Decode accesses; the write takes priority over the read.
    always_comb begin
        wr_acc = !load_n && !wr_en_n;
        rd_req = !load_n && !rd_en1_n && !rd_en2_n;
        rd_stb = rd_req && !wr_acc;
    end

    flag_offset_seq_sel u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (wr_acc || rd_req),
        .sel   (sel)
    );

    flag_offset_seq_bank #(.DIN_W(DIN_W), .HI_W(HI_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_acc),
        .sel    (sel),
        .din    (din),
        .lo_q   (lo_q),
        .hi_q   (hi_q)
    );

    flag_offset_seq_rdmux #(.HI_W(HI_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .clash_in   (wr_acc && rd_req),
        .sel        (sel),
        .lo_q       (lo_q),
        .hi_q       (hi_q),
        .rdback     (rdback),
        .rdback_vld (rdback_vld),
        .clash      (clash)
    );

    // Assemble the offsets for the flag comparators.
    always_comb begin
        empty_ofs = {hi_q[0], lo_q[0]};
        full_ofs  = {hi_q[1], lo_q[1]};
    end

endmodule

// File: rtl/flag_offset_seq_chk.sv
// Port-level checker for flag_offset_seq, attached with bind.
module flag_offset_seq_chk #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned DIN_W = 9,
    localparam int unsigned OFS_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             wr_en_n,
    input logic             rd_en1_n,
    input logic             rd_en2_n,
    input logic [DIN_W-1:0] din,
    input logic [OFS_W-1:0] empty_ofs,
    input logic [OFS_W-1:0] full_ofs,
    input logic [7:0]       rdback,
    input logic             rdback_vld,
    input logic             clash
);

    logic w_req, r_req;
    always_comb begin
        w_req = !load_n && !wr_en_n;
        r_req = !load_n && !rd_en1_n && !rd_en2_n;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (empty_ofs == OFS_W'(7) && full_ofs == OFS_W'(7) && !rdback_vld && !clash));

    // R5
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_req && !w_req) |=> rdback_vld);

    // R11
    no_rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_req |=> !rdback_vld);

    // R8
    clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_req && r_req) |=> (clash && !rdback_vld));

    // R8
    no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_req && r_req) |=> !clash);

    // R4
    hold_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w_req |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

bind flag_offset_seq flag_offset_seq_chk #(.DEPTH(DEPTH), .DIN_W(DIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .wr_en_n    (wr_en_n),
    .rd_en1_n   (rd_en1_n),
    .rd_en2_n   (rd_en2_n),
    .din        (din),
    .empty_ofs  (empty_ofs),
    .full_ofs   (full_ofs),
    .rdback     (rdback),
    .rdback_vld (rdback_vld),
    .clash      (clash)
);

// File: tb/flag_offset_seq_test.sv
// Scoreboard bench: step() predicts each cycle's result and queues it;
// the monitor pops one item per clock and compares it to the outputs.
module flag_offset_seq_test;

    localparam int unsigned DEPTH = 1024;
    localparam int unsigned OFS_W = $clog2(DEPTH);
    localparam int unsigned HI_W  = OFS_W - 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_n = 1'b1, wr_en_n = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic [8:0]       din = '0;
    logic [OFS_W-1:0] empty_ofs, full_ofs;
    logic [7:0]       rdback;
    logic             rdback_vld, clash;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic       vld;
        logic [7:0] data;
        logic       clsh;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    // Model state built from the requirements.
    logic [7:0]      m_lo [2];
    logic [HI_W-1:0] m_hi [2];
    int              m_sel;

    always #10 clk = ~clk;

    flag_offset_seq #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .din(din),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .rdback(rdback), .rdback_vld(rdback_vld), .clash(clash)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] model_get(input int s);
        case (s)
            0: return m_lo[0];
            1: return 8'(m_hi[0]);
            2: return m_lo[1];
            default: return 8'(m_hi[1]);
        endcase
    endfunction

    task automatic model_reset();
        m_lo[0] = 8'd7; m_lo[1] = 8'd7;
        m_hi[0] = '0;   m_hi[1] = '0;
        m_sel   = 0;
    endtask

    // One cycle: drive inputs, predict the result, wait past the edge, check offsets.
    task automatic step(input bit ld, input bit we, input bit r1, input bit r2,
                        input logic [8:0] d, input string req);
        bit   wr, rd;
        exp_t e;
        load_n = ld; wr_en_n = we; rd_en1_n = r1; rd_en2_n = r2; din = d;
        wr = !ld && !we;
        rd = !ld && !r1 && !r2;
        e.vld  = rd && !wr;
        e.data = model_get(m_sel);
        e.clsh = wr && rd;
        e.req  = req;
        if (wr) begin
            case (m_sel)
                0: m_lo[0] = d[7:0];
                1: m_hi[0] = d[HI_W-1:0];
                2: m_lo[1] = d[7:0];
                default: m_hi[1] = d[HI_W-1:0];
            endcase
        end
        if (wr || rd) m_sel = (m_sel + 1) % 4;
        exp_q.push_back(e);
        @(posedge clk);
        #5;
        check(empty_ofs == {m_hi[0], m_lo[0]}, req, "empty_ofs", empty_ofs, {m_hi[0], m_lo[0]});
        check(full_ofs  == {m_hi[1], m_lo[1]}, req, "full_ofs",  full_ofs,  {m_hi[1], m_lo[1]});
    endtask

    task automatic wr_step(input logic [8:0] d, input string req);
        step(1'b0, 1'b0, 1'b1, 1'b1, d, req);
    endtask

    task automatic rd_step(input string req);
        step(1'b0, 1'b1, 1'b0, 1'b0, 9'h0, req);
    endtask

    task automatic do_reset();
        load_n = 1'b1; wr_en_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        rst_n = 1'b1;
        model_reset();
        // R1: reset state at the ports
        check(empty_ofs == OFS_W'(7), "R1", "empty_ofs", empty_ofs, 7);
        check(full_ofs  == OFS_W'(7), "R1", "full_ofs",  full_ofs,  7);
        check(rdback == 8'h0, "R1", "rdback", rdback, 0);
        check(!rdback_vld, "R1", "rdback_vld", rdback_vld, 0);
        check(!clash, "R1", "clash", clash, 0);
    endtask

    // Monitor: one expected item per clock once steps are running.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(rdback_vld == e.vld, e.req, "rdback_vld", rdback_vld, e.vld);
                check(clash == e.clsh, e.req, "clash", clash, e.clsh);
                if (e.vld)
                    check(rdback == e.data, e.req, "rdback", rdback, e.data);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R5 R6 R1: read the defaults in order, then wrap (R3)
        rd_step("R5");
        rd_step("R6");
        rd_step("R6");
        rd_step("R6");
        rd_step("R3");
        rd_step("R3");
        rd_step("R3");
        rd_step("R3");

        // R2 R7 R10: full load; bit 8 and upper high bits dropped
        wr_step(9'h1A5, "R2");
        wr_step(9'h1FF, "R7");
        wr_step(9'h03C, "R10");
        wr_step(9'h102, "R10");
        // R3: fifth write wraps to empty low
        wr_step(9'h055, "R3");

        // R7: readback of the loaded set, high parts zero-extended
        rd_step("R7");
        rd_step("R7");
        rd_step("R7");
        rd_step("R7");

        // R4: partial load, then normal mode with enables active
        wr_step(9'h011, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b0, 9'h0EE, "R4");
        step(1'b1, 1'b0, 1'b1, 1'b1, 9'h0DD, "R4");
        step(1'b1, 1'b1, 1'b1, 1'b1, 9'h0CC, "R4");
        wr_step(9'h0F0, "R4");
        wr_step(9'h001, "R4");

        // R11: only one read enable low
        step(1'b0, 1'b1, 1'b0, 1'b1, 9'h0, "R11");
        step(1'b0, 1'b1, 1'b1, 1'b0, 9'h0, "R11");
        rd_step("R11");

        // R8: simultaneous request, write wins
        step(1'b0, 1'b0, 1'b0, 1'b0, 9'h0AB, "R8");
        rd_step("R8");
        rd_step("R6");
        rd_step("R6");
        rd_step("R6");

        // R9: reset mid-sequence returns the pointer to empty low
        wr_step(9'h033, "R9");
        do_reset();
        rd_step("R9");
        wr_step(9'h044, "R9");
        rd_step("R9");
        step(1'b1, 1'b1, 1'b1, 1'b1, 9'h0, "R5");
        step(1'b1, 1'b1, 1'b1, 1'b1, 9'h0, "R5");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule